// File: doc/BRIEF.md
# Short-Circuit Filter and Fault Latch

This block protects two half bridges, four power switches in all. A comparator outside the block raises one flag per switch when that switch's drain-source voltage is above its trip threshold. When such a flag stays high, with the switch's gate enabled and detection armed, for a programmable number of consecutive clock cycles, the block latches a fault for the whole half bridge. The fault forces both of that bridge's switches off until a clear pulse arrives. The count never accumulates: any cycle in which the condition drops restarts it.

Undervoltage flags, one per output, force only their own output off. This takes effect in the same cycle as the flag, and the output returns by itself once the flag falls. The four force-off bits feed the downstream gate enable logic. An active-low error flag goes low whenever any force-off bit is set.

Top module: `sc_guard`

## Requirements
- R1: A switch's fault condition holds in a cycle when its gate enable, over-threshold flag and detection enable are all 1. The bridge latch sets at the clock edge that completes `filt_len_i` consecutive cycles with the condition held. A `filt_len_i` of 0 or 1 sets the latch at the first such edge.
- R2: A single cycle without the condition restarts that switch's count from zero. Repeated runs shorter than `filt_len_i` never set the latch, however many there are.
- R3: Switch index 2b is the high side of bridge b and index 2b+1 is its low side. A trip on either switch sets force-off bits 2b and 2b+1, and both stay set after the condition goes away.
- R4: A trip in one bridge leaves the force-off bits of the other bridge at 0.
- R5: `uv_i[i]` sets `force_off_o[i]` in the same cycle and affects no other bit. The bit clears once `uv_i[i]` is 0, and nothing is latched.
- R6: With `sc_en_i[i]` at 0, switch i never sets a latch, whatever its other inputs do.
- R7: With `gate_on_i[i]` at 0, switch i does not count, even while its over-threshold flag is high.
- R8: A one-cycle `clr_i` clears every bridge latch and every count. It overrides a trip that happens at the same edge. If the condition persists, the latch sets again only after a fresh full run of `filt_len_i` cycles.
- R9: `err_no` is 1 exactly when all force-off bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_on_i | input | 4 | Gate enable per switch; counting is allowed only while this is high |
| vds_over_i | input | 4 | Over-threshold comparator flag per switch |
| sc_en_i | input | 4 | Short-circuit detection enable per switch |
| uv_i | input | 4 | Undervoltage flag per output |
| filt_len_i | input | CNT_W | Filter length in clock cycles |
| clr_i | input | 1 | Clears all fault latches and counts |
| force_off_o | output | 4 | Force-off request per switch |
| err_no | output | 1 | Error flag, active low |

## Verification
Two functions can land on the same edge: a clear pulse and the edge that completes a filter run. The bench makes them meet by asserting `clr_i` in the very cycle whose edge would set the latch. It then expects every force-off bit to be 0 after that edge. With the condition still held, it expects the latch to stay clear for `filt_len_i`-1 further edges and to set on the next one. A second overlap, undervoltage on an output whose bridge is already latched, is judged by dropping the undervoltage flag and confirming the bit remains set because the latch still holds it.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned SW_PER_BRIDGE = 2;

  typedef enum logic {SIDE_HIGH = 1'b0, SIDE_LOW = 1'b1} side_e;

  function automatic int unsigned bridge_of(int unsigned sw);
    return sw / SW_PER_BRIDGE;
  endfunction
endpackage

// File: rtl/sc_filter.sv
module sc_filter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_on_i,
  input  logic             over_i,
  input  logic             det_en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             trip_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             active;
  logic [CNT_W-1:0] cnt_q, cnt_inc;

  assign active  = gate_on_i & over_i & det_en_i;
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  // cnt_inc is the length of the current run including this cycle
  assign trip_o  = active && (cnt_inc >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !active)  cnt_q <= '0;
    else                        cnt_q <= cnt_inc;
  end

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (cnt_q == '0)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || cnt_q == '0)); // R1
endmodule

// File: rtl/sc_bridge_latch.sv
module sc_bridge_latch (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] trip_i,
  input  logic       clr_i,
  output logic       lat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lat_o <= 1'b0;
    else if (clr_i) lat_o <= 1'b0;   // clear beats a same-edge trip
    else if (|trip_i) lat_o <= 1'b1;
  end

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !lat_o); // R8
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_o && !clr_i) |=> lat_o); // R3
endmodule

// File: rtl/sc_guard.sv
module sc_guard #(
  parameter int unsigned N_BRIDGE = 2,
  parameter int unsigned CNT_W    = 16,
  localparam int unsigned N_SW    = N_BRIDGE * sc_pkg::SW_PER_BRIDGE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SW-1:0]  gate_on_i,
  input  logic [N_SW-1:0]  vds_over_i,
  input  logic [N_SW-1:0]  sc_en_i,
  input  logic [N_SW-1:0]  uv_i,
  input  logic [CNT_W-1:0] filt_len_i,
  input  logic             clr_i,
  output logic [N_SW-1:0]  force_off_o,
  output logic             err_no
);
  logic [N_SW-1:0]     trip;
  logic [N_BRIDGE-1:0] lat;

  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    sc_filter #(.CNT_W(CNT_W)) u_filt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .gate_on_i (gate_on_i[i]),
      .over_i    (vds_over_i[i]),
      .det_en_i  (sc_en_i[i]),
      .clr_i     (clr_i),
      .limit_i   (filt_len_i),
      .trip_o    (trip[i])
    );

    assign force_off_o[i] = lat[sc_pkg::bridge_of(i)] | uv_i[i];

    AST_TRIP_TO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trip[i] && !clr_i) |=> force_off_o[i] && force_off_o[i ^ 1]); // R3
  end

  for (genvar b = 0; b < N_BRIDGE; b++) begin : g_br
    sc_bridge_latch u_lat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .trip_i ({trip[2*b+sc_pkg::SIDE_LOW], trip[2*b+sc_pkg::SIDE_HIGH]}),
      .clr_i  (clr_i),
      .lat_o  (lat[b])
    );
  end

  assign err_no = ~|force_off_o;
endmodule

// File: tb/tb_sc_guard.sv
module tb_sc_guard;
  localparam int CNT_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [3:0]       gate_on_i = '0, vds_over_i = '0, sc_en_i = '1, uv_i = '0;
  logic [CNT_W-1:0] filt_len_i = '0;
  logic             clr_i = 1'b0;
  logic [3:0]       force_off_o;
  logic             err_no;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sc_guard #(.N_BRIDGE(2), .CNT_W(CNT_W)) dut (.*);

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] br_mask(int s);
    return 4'b0011 << (2 * (s / 2));
  endfunction

  task automatic clear();
    gate_on_i = '0; vds_over_i = '0; uv_i = '0; sc_en_i = '1;
    clr_i = 1'b1; step(); clr_i = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    check("R9 reset", {force_off_o, err_no}, 5'b00001);
    rst_ni = 1'b1; step();

    // R1 R3 R4 sweep: switch x filter length x run length
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 6; l++) begin
        for (int n = 1; n < 8; n++) begin
          int eff;
          clear();
          filt_len_i = CNT_W'(l);
          eff = (l < 1) ? 1 : l;
          gate_on_i[s] = 1'b1; vds_over_i[s] = 1'b1;
          for (int k = 1; k <= n; k++) begin
            step();
            check("R1 R3 R4 R9 run", {force_off_o, err_no},
                  (k >= eff) ? {br_mask(s), 1'b0} : 5'b00001);
          end
          vds_over_i[s] = 1'b0; gate_on_i[s] = 1'b0;
          step();
          check("R3 hold", {force_off_o, err_no},
                (n >= eff) ? {br_mask(s), 1'b0} : 5'b00001);
        end
      end
    end

    // R2: repeated runs shorter than the filter never trip
    clear(); filt_len_i = 8'd4; gate_on_i = 4'b0100;
    for (int r = 0; r < 6; r++) begin
      vds_over_i[2] = 1'b1; repeat (3) step();
      vds_over_i[2] = 1'b0; step();
    end
    check("R2 no accumulate", {force_off_o, err_no}, 5'b00001);
    vds_over_i[2] = 1'b1; repeat (4) step();
    check("R2 full run trips", {force_off_o, err_no}, 5'b11000);

    // R6: detection disabled
    clear(); filt_len_i = 8'd2; sc_en_i = 4'b1101; gate_on_i = 4'b0010; vds_over_i = 4'b0010;
    repeat (10) step();
    check("R6 disabled", {force_off_o, err_no}, 5'b00001);

    // R7: gate off, no counting
    clear(); filt_len_i = 8'd2; gate_on_i = 4'b0000; vds_over_i = 4'b1000;
    repeat (10) step();
    check("R7 gate off", {force_off_o, err_no}, 5'b00001);
    gate_on_i[3] = 1'b1; step();
    check("R7 restart count", {force_off_o, err_no}, 5'b00001);
    step();
    check("R7 then trips", {force_off_o, err_no}, 5'b11000);

    // R5: undervoltage per output, immediate, self-recovering
    for (int s = 0; s < 4; s++) begin
      clear();
      uv_i[s] = 1'b1; #1;
      check("R5 uv set", {force_off_o, err_no}, {4'b0001 << s, 1'b0});
      step();
      uv_i[s] = 1'b0; #1;
      check("R5 uv recover", {force_off_o, err_no}, 5'b00001);
    end

    // R5 + latch overlap: uv drop leaves latched bit set
    clear(); filt_len_i = 8'd1; gate_on_i = 4'b0001; vds_over_i = 4'b0001; uv_i = 4'b0010;
    step(); vds_over_i = '0; uv_i = '0; #1;
    check("R5 R3 overlap", {force_off_o, err_no}, 5'b00110);

    // R8: clear at the edge that would trip
    clear(); filt_len_i = 8'd3; gate_on_i = 4'b0001; vds_over_i = 4'b0001;
    step(); step();
    clr_i = 1'b1; step(); clr_i = 1'b0;
    check("R8 clear wins", {force_off_o, err_no}, 5'b00001);
    step(); step();
    check("R8 fresh interval", {force_off_o, err_no}, 5'b00001);
    step();
    check("R8 retrip", {force_off_o, err_no}, 5'b00110);
    vds_over_i = '0; gate_on_i = '0;
    clr_i = 1'b1; step(); clr_i = 1'b0;
    check("R8 clear latched", {force_off_o, err_no}, 5'b00001);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule